// File: doc/BRIEF.md
# Privilege Mode and Protection Unit

This unit sits next to a simple processor core and polices what code running in user mode may do. It holds a one-bit execution mode, a base/limit address window, and a countdown timer that takes control back from user code. Every memory request from the core is checked against the window while the unit is in user mode. In supervisor mode every request is allowed. Requests for I/O, writes to the window registers and loads of the timer are all privileged. The unit grants them only in supervisor mode.

When user code breaks a rule, when the timer runs out, or when the external interrupt line is raised, the unit stops user execution. It pulses a trap request with a cause code and drops into supervisor mode in the same cycle. While the unit is in supervisor mode, incoming interrupts and timer expiry are held off. The supervisor leaves with a return-to-user command, and that command also re-enables interrupts.

The behaviour is built around two named states. `ST_SUPER` is the reset state: privileged and masked. `ST_USER` is unprivileged with interrupts open. There are two transitions. `RETURN` goes from `ST_SUPER` to `ST_USER` on the return command. `TRAP` goes from `ST_USER` to `ST_SUPER` on any trap condition.

Top module: `priv_guard`

## Requirements
- R1: `mode_user` is 0 in supervisor mode and 1 in user mode. The values of `trap_cause` are 0 for a protection violation, 1 for a privileged-operation violation, 2 for timer expiry and 3 for the external interrupt.
- R2: After reset the unit is in supervisor mode and `trap_valid` is low.
- R3: A trap is taken on a clock edge. After that edge `trap_valid` is high for exactly one cycle, `trap_cause` holds the winning cause, and `mode_user` is 0.
- R4: In supervisor mode every access is granted regardless of address, `io_grant` follows `io_req`, and writes to base, limit and timer take effect. None of these raises a trap.
- R5: In user mode an access is granted in the same cycle only when base <= addr < base + limit. Any other access is refused and raises a protection trap on the next edge.
- R6: In user mode, `io_req`, `base_wr`, `limit_wr` and `timer_wr` are each refused. None of them changes any register, and each raises a privileged-operation trap.
- R7: A timer loaded with N > 0 decrements by one on every clock edge after the load. If the unit is in user mode, a timer trap is taken on the (N+1)-th edge after the load edge.
- R8: A timer that has reached zero, or has been loaded with zero, stays stopped and raises no further trap until it is reloaded.
- R9: In supervisor mode the external interrupt and timer expiry raise no trap. A timer expiry is held pending and traps on the first edge after the return to user mode.
- R10: When several causes are present together, the lowest cause code wins: protection, then privilege, then timer, then external.
- R11: `ret_user` in supervisor mode sets user mode on the next edge. In user mode it is ignored, raises no trap and leaves the mode unchanged.
- R12: In user mode a high `ext_irq` raises an external-interrupt trap on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access request |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_grant | output | 1 | Access allowed (combinational) |
| io_req | input | 1 | Privileged I/O operation request |
| io_grant | output | 1 | I/O operation allowed (combinational) |
| base_wr | input | 1 | Request to write the window base |
| limit_wr | input | 1 | Request to write the window size |
| wr_data | input | ADDR_W | Value for base or limit writes |
| timer_wr | input | 1 | Request to load the timer |
| timer_data | input | TMR_W | Timer load value |
| ext_irq | input | 1 | External interrupt, level sensitive |
| ret_user | input | 1 | Return-to-user command |
| trap_valid | output | 1 | One-cycle trap/interrupt request |
| trap_cause | output | 2 | Cause of the current trap |
| mode_user | output | 1 | Current mode, 1 = user |

## Verification
The assertions assume that every input is stable around the rising clock edge and that `rst_n` is held low before the first edge. They also assume `ext_irq` is a level that the surrounding system keeps high until it is serviced. The bench changes inputs only on falling edges and starts with reset asserted. It holds `ext_irq` high only in the cycles where it means to request an interrupt. It returns `base_wr`, `limit_wr`, `timer_wr`, `io_req` and `ret_user` to zero after each cycle, so every trap can be traced to a single intended cause.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;
    typedef enum logic {
        ST_SUPER = 1'b0,
        ST_USER  = 1'b1
    } mode_e;

    localparam int NUM_CAUSE = 4;
    localparam int CAUSE_W   = $clog2(NUM_CAUSE);

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_PROT  = 2'd0,
        CAUSE_PRIV  = 2'd1,
        CAUSE_TIMER = 2'd2,
        CAUSE_EXT   = 2'd3
    } cause_e;
endpackage

// File: rtl/priv_range_chk.sv
module priv_range_chk #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              limit_we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else begin
            if (base_we)  base_q  <= wdata;
            if (limit_we) limit_q <= wdata;
        end
    end

    // The offset compare avoids the carry out of base + limit.
    always_comb begin
        offset   = addr - base_q;
        in_range = (addr >= base_q) && (offset < limit_q);
    end
endmodule

// File: rtl/priv_timer.sv
module priv_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             disarm,
    output logic             expired
);
    logic [TMR_W-1:0] count_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            count_q <= load_val;
            armed_q <= (load_val != '0);
        end else begin
            if (count_q != '0) count_q <= count_q - 1'b1;
            if (disarm)        armed_q <= 1'b0;
        end
    end

    assign expired = armed_q && (count_q == '0);
endmodule

// File: rtl/priv_cause_arb.sv
module priv_cause_arb
    import priv_guard_pkg::*;
#(
    parameter int N = NUM_CAUSE
) (
    input  logic [N-1:0]       req,
    output logic               any,
    output logic [CAUSE_W-1:0] winner
);
    // Lower index has higher priority.
    always_comb begin
        any    = 1'b0;
        winner = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any    = 1'b1;
                winner = CAUSE_W'(i);
            end
        end
    end
endmodule

// File: rtl/priv_guard.sv
module priv_guard
    import priv_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_grant,
    input  logic              io_req,
    output logic              io_grant,
    input  logic              base_wr,
    input  logic              limit_wr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              timer_wr,
    input  logic [TMR_W-1:0]  timer_data,
    input  logic              ext_irq,
    input  logic              ret_user,
    output logic              trap_valid,
    output logic [1:0]        trap_cause,
    output logic              mode_user
);
    mode_e               state_q, state_d;
    logic                is_user;
    logic                in_range;
    logic                tmr_expired;
    logic [NUM_CAUSE-1:0] viol;
    logic                take_trap;
    logic [CAUSE_W-1:0]  win_cause;
    logic                priv_req;

    assign is_user  = (state_q == ST_USER);
    assign priv_req = io_req | base_wr | limit_wr | timer_wr;

    priv_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_we  (base_wr && !is_user),
        .limit_we (limit_wr && !is_user),
        .wdata    (wr_data),
        .addr     (acc_addr),
        .in_range (in_range)
    );

    priv_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_wr && !is_user),
        .load_val (timer_data),
        .disarm   (take_trap && (win_cause == CAUSE_TIMER)),
        .expired  (tmr_expired)
    );

    always_comb begin
        viol              = '0;
        viol[CAUSE_PROT]  = is_user && acc_valid && !in_range;
        viol[CAUSE_PRIV]  = is_user && priv_req;
        viol[CAUSE_TIMER] = is_user && tmr_expired;
        viol[CAUSE_EXT]   = is_user && ext_irq;
    end

    priv_cause_arb #(.N(NUM_CAUSE)) u_arb (
        .req    (viol),
        .any    (take_trap),
        .winner (win_cause)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SUPER;
        else        state_q <= state_d;
    end

    // Transitions: RETURN and TRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPER: if (ret_user)  state_d = ST_USER;
            ST_USER:  if (take_trap) state_d = ST_SUPER;
        endcase
    end

    // Registered trap outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end else begin
            trap_valid <= take_trap;
            if (take_trap) trap_cause <= win_cause;
        end
    end

    assign mode_user = is_user;
    assign acc_grant = acc_valid && (!is_user || in_range);
    assign io_grant  = io_req && !is_user;
endmodule

// File: rtl/priv_guard_sva.sv
module priv_guard_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_grant,
    input logic       io_req,
    input logic       io_grant,
    input logic       ext_irq,
    input logic       ret_user,
    input logic       trap_valid,
    input logic [1:0] trap_cause,
    input logic       mode_user
);
    AST_TRAP_TO_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !mode_user); // R3
    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid); // R3
    AST_SUPER_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_user && acc_valid) |-> acc_grant); // R4
    AST_USER_REFUSE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_user && acc_valid && !acc_grant) |=> (trap_valid && trap_cause == 2'd0)); // R5
    AST_USER_IO_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_user && io_req) |-> !io_grant); // R6
    AST_SUPER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_user |=> !trap_valid); // R9
    AST_RETURN_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_user && ret_user) |=> mode_user); // R11
    AST_USER_EXT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_user && ext_irq) |=> trap_valid); // R12
endmodule

bind priv_guard priv_guard_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_grant  (acc_grant),
    .io_req     (io_req),
    .io_grant   (io_grant),
    .ext_irq    (ext_irq),
    .ret_user   (ret_user),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause),
    .mode_user  (mode_user)
);

// File: tb/tb_priv_guard.sv
`timescale 1ns/1ps
module tb_priv_guard;
    localparam int AW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_grant;
    logic          io_req = 1'b0;
    logic          io_grant;
    logic          base_wr = 1'b0;
    logic          limit_wr = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic          timer_wr = 1'b0;
    logic [TW-1:0] timer_data = '0;
    logic          ext_irq = 1'b0;
    logic          ret_user = 1'b0;
    logic          trap_valid;
    logic [1:0]    trap_cause;
    logic          mode_user;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    priv_guard #(.ADDR_W(AW), .TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_grant(acc_grant), .io_req(io_req), .io_grant(io_grant),
        .base_wr(base_wr), .limit_wr(limit_wr), .wr_data(wr_data),
        .timer_wr(timer_wr), .timer_data(timer_data), .ext_irq(ext_irq),
        .ret_user(ret_user), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .mode_user(mode_user)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_user();
        ret_user = 1'b1;
        tick();
        ret_user = 1'b0;
        chk("R11 enter user", mode_user, 1);
    endtask

    // Leave user mode through an external interrupt (R12)
    task automatic back_super();
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
        chk("R12 ext trap", trap_valid, 1);
        chk("R12 ext cause", trap_cause, 3);
        chk("R3 mode after trap", mode_user, 0);
    endtask

    task automatic quiet(input string r, input int n);
        int hits = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (trap_valid) hits++;
        end
        chk(r, hits, 0);
    endtask

    task automatic t_reset();
        chk("R2 reset mode", mode_user, 0);
        chk("R2 reset trap", trap_valid, 0);
    endtask

    task automatic t_super();
        base_wr = 1'b1; wr_data = 16'h0100; tick(); base_wr = 1'b0;
        limit_wr = 1'b1; wr_data = 16'h0040; tick(); limit_wr = 1'b0;
        acc_valid = 1'b1; acc_addr = 16'h0000; #1;
        chk("R4 super low addr", acc_grant, 1);
        acc_addr = 16'hFFFF; io_req = 1'b1; #1;
        chk("R4 super high addr", acc_grant, 1);
        chk("R4 super io", io_grant, 1);
        tick();
        acc_valid = 1'b0; io_req = 1'b0;
        chk("R4 no trap", trap_valid, 0);
        chk("R4 stays super", mode_user, 0);
    endtask

    task automatic t_range();
        go_user();
        acc_valid = 1'b1; acc_addr = 16'h0100; #1;
        chk("R5 base granted", acc_grant, 1);
        tick();
        chk("R5 in range no trap", trap_valid, 0);
        acc_addr = 16'h013F; #1;
        chk("R5 top granted", acc_grant, 1);
        tick();
        acc_addr = 16'h0140; #1;
        chk("R5 base+limit refused", acc_grant, 0);
        tick();
        acc_valid = 1'b0;
        chk("R5 trap", trap_valid, 1);
        chk("R1 prot cause", trap_cause, 0);
        chk("R3 mode super", mode_user, 0);
        tick();
        chk("R3 single pulse", trap_valid, 0);
        go_user();
        acc_valid = 1'b1; acc_addr = 16'h00FF; #1;
        chk("R5 below base refused", acc_grant, 0);
        tick();
        acc_valid = 1'b0;
        chk("R5 below base trap", trap_cause, 0);
        chk("R5 below base trap valid", trap_valid, 1);
    endtask

    task automatic t_priv();
        go_user();
        io_req = 1'b1; #1;
        chk("R6 io refused", io_grant, 0);
        tick(); io_req = 1'b0;
        chk("R6 io trap", trap_valid, 1);
        chk("R6 io cause", trap_cause, 1);
        go_user();
        base_wr = 1'b1; wr_data = 16'h0000; tick(); base_wr = 1'b0;
        chk("R6 base_wr cause", trap_cause, 1);
        go_user();
        limit_wr = 1'b1; wr_data = 16'hFFFF; tick(); limit_wr = 1'b0;
        chk("R6 limit_wr cause", trap_cause, 1);
        go_user();
        acc_valid = 1'b1; acc_addr = 16'h0100; #1;
        chk("R6 base unchanged", acc_grant, 1);
        acc_addr = 16'h0050; #1;
        chk("R6 base not lowered", acc_grant, 0);
        acc_addr = 16'h0140; #1;
        chk("R6 limit unchanged", acc_grant, 0);
        acc_valid = 1'b0; #1;
        back_super();
        go_user();
        timer_wr = 1'b1; timer_data = 16'd3; tick(); timer_wr = 1'b0;
        chk("R6 timer_wr cause", trap_cause, 1);
        go_user();
        quiet("R6 timer not loaded", 10);
        back_super();
    endtask

    task automatic t_timer();
        timer_wr = 1'b1; timer_data = 16'd5; ret_user = 1'b1;
        tick();
        timer_wr = 1'b0; ret_user = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            tick();
            if (k < 6) chk("R7 no early trap", trap_valid, 0);
            else begin
                chk("R7 timer trap", trap_valid, 1);
                chk("R7 timer cause", trap_cause, 2);
            end
        end
        go_user();
        quiet("R8 stopped at zero", 20);
        back_super();
        timer_wr = 1'b1; timer_data = 16'd0; ret_user = 1'b1;
        tick();
        timer_wr = 1'b0; ret_user = 1'b0;
        quiet("R8 zero load disabled", 10);
        back_super();
    endtask

    task automatic t_mask();
        ext_irq = 1'b1;
        quiet("R9 ext masked", 3);
        chk("R9 still super", mode_user, 0);
        ret_user = 1'b1; tick(); ret_user = 1'b0;
        chk("R9 user after return", mode_user, 1);
        chk("R9 no trap yet", trap_valid, 0);
        tick();
        ext_irq = 1'b0;
        chk("R12 ext after unmask", trap_cause, 3);
        timer_wr = 1'b1; timer_data = 16'd2; tick(); timer_wr = 1'b0;
        quiet("R9 expiry held", 8);
        go_user();
        tick();
        chk("R9 pending timer trap", trap_valid, 1);
        chk("R9 pending timer cause", trap_cause, 2);
    endtask

    task automatic t_prio();
        go_user();
        acc_valid = 1'b1; acc_addr = 16'h0000; io_req = 1'b1; ext_irq = 1'b1;
        tick();
        acc_valid = 1'b0; io_req = 1'b0; ext_irq = 1'b0;
        chk("R10 prot wins", trap_cause, 0);
        go_user();
        io_req = 1'b1; ext_irq = 1'b1; tick();
        io_req = 1'b0; ext_irq = 1'b0;
        chk("R10 priv over ext", trap_cause, 1);
        timer_wr = 1'b1; timer_data = 16'd1; tick(); timer_wr = 1'b0;
        tick(); tick();
        ext_irq = 1'b1;
        go_user();
        tick();
        chk("R10 timer over ext", trap_cause, 2);
        go_user();
        tick();
        ext_irq = 1'b0;
        chk("R10 ext after timer", trap_cause, 3);
    endtask

    task automatic t_ret_ignore();
        go_user();
        ret_user = 1'b1; tick(); ret_user = 1'b0;
        chk("R11 ret in user mode", mode_user, 1);
        chk("R11 ret in user no trap", trap_valid, 0);
        back_super();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_super();
        t_range();
        t_priv();
        t_timer();
        t_mask();
        t_prio();
        t_ret_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule